// File: doc/BRIEF.md
# Instruction Fetch Cache Controller

This block is a read-only, direct-mapped instruction cache that sits between a processor's fetch stage and a narrower memory read port. The processor presents a word address every cycle. The cache answers one clock edge later with the instruction word and a stall flag. Each entry holds a valid flag, a tag and a line of several words. The line words sit in synchronous RAM banks, one bank per memory-bus slice of a word, so block RAM can be inferred.

After reset a controller walks every set and clears its valid flag, holding the processor stalled for the whole sweep. It then compares tags on every fetch. A miss raises the stall and fetches the whole line from memory in consecutive beats. Each beat is written into its place in the line. The edge that accepts the final beat releases the stall and delivers the requested word directly, without a second lookup. The processor may change its address only in a cycle where the stall output is low.

Top module: `ifetch_cache`

## Requirements
- R1: The CPU address is a word address. Its low log2(LINE_WORDS) bits select the word in the line, the next log2(SETS) bits select the set, and the remaining upper bits form the tag that must match the stored tag of a valid entry for a hit.
- R2: After reset the controller clears the valid flag of every set, one set per cycle, for SETS cycles. During this sweep cpu_stall stays high and mem_rd stays low. After any reset, every previously loaded line misses.
- R3: cpu_instr and cpu_stall after each clock edge describe the address held before that edge. A hit gives cpu_stall low after one edge with the stored word, and mem_rd stays low.
- R4: On a miss cpu_stall goes high and mem_rd goes high. mem_addr is {line address, beat number}, where the line address is the CPU address without its word-offset bits. The beat number starts at 0 and rises by one per accepted beat, for BEATS = LINE_WORDS*WORD_W/MEM_W beats.
- R5: A beat is accepted only at an edge where mem_stall is low. While mem_stall is high, mem_addr holds, and the miss takes one more cycle for each stalled cycle.
- R6: Beat b of a line belongs to word b/(WORD_W/MEM_W) of the line. It fills that word's bits starting at (b mod (WORD_W/MEM_W))*MEM_W, so part 0 is the least significant slice.
- R7: The edge that accepts the last beat drives cpu_stall low and mem_rd low and presents the requested word on cpu_instr. A miss therefore takes 1 + BEATS + (stalled cycles) edges.
- R8: Once loaded, a line hits on every later fetch to it, until a fetch with another tag but the same index replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | Fetch word address |
| cpu_instr | output | WORD_W | Instruction word for the previous address |
| cpu_stall | output | 1 | High while the answer is not valid |
| mem_addr | output | ADDR_W-log2(LINE_WORDS)+log2(BEATS) | Beat address of the line being loaded |
| mem_rd | output | 1 | Memory read request |
| mem_data | input | MEM_W | Beat data, valid when mem_rd is high and mem_stall is low |
| mem_stall | input | 1 | Memory not ready; beat not taken |

## Verification
The bound checker watches the port-level protocol on every cycle. It checks that the processor stays stalled with no memory read during the post-reset sweep, and that no memory read happens without a stall. It also checks that each refill starts at beat zero, that the beat address steps by one per accepted beat and holds under memory stall, and that the final beat releases the stall together with the request. The correctness of delivered words, the placement of beats inside a line, the hit/miss decision from the field split, eviction of a conflicting tag, and the loss of lines after a reset can only be shown by the bench. It sweeps sequential and conflicting addresses under three memory-stall patterns and compares every word and latency against an arithmetic memory model and its own tag shadow.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [1:0] {
    ST_SWEEP  = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_FILL   = 2'd2
  } ifc_state_e;
endpackage

// File: rtl/ifc_tag_store.sv
module ifc_tag_store #(
  parameter int SETS  = 8,
  parameter int IDX_W = 3,
  parameter int TAG_W = 7
) (
  input  logic             clk,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag,
  input  logic [IDX_W-1:0] look_idx,
  input  logic [TAG_W-1:0] look_tag,
  output logic             look_hit
);
  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_q [SETS];

  // valid flags are cleared by the sweep, not by reset
  always_ff @(posedge clk) begin
    if (clr_en) begin
      valid_q[clr_idx] <= 1'b0;
    end else if (set_en) begin
      valid_q[set_idx] <= 1'b1;
      tag_q[set_idx]   <= set_tag;
    end
  end

  assign look_hit = valid_q[look_idx] && (tag_q[look_idx] == look_tag);
endmodule

// File: rtl/ifc_data_bank.sv
module ifc_data_bank #(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int W     = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ifc_ctrl.sv
module ifc_ctrl
  import ifc_pkg::*;
#(
  parameter int SETS   = 8,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 7,
  parameter int OFF_W  = 2,
  parameter int PART_W = 1,
  parameter int BPW    = 2,
  parameter int BEAT_W = 3,
  parameter int BEATS  = 8,
  parameter int MEM_W  = 16,
  parameter int WORD_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [TAG_W-1:0]         req_tag,
  input  logic [IDX_W-1:0]         req_idx,
  input  logic [OFF_W-1:0]         req_off,
  input  logic                     look_hit,
  input  logic [MEM_W-1:0]         mem_data,
  input  logic                     mem_stall,
  output logic                     clr_en,
  output logic [IDX_W-1:0]         clr_idx,
  output logic                     set_en,
  output logic [IDX_W-1:0]         set_idx,
  output logic [TAG_W-1:0]         set_tag,
  output logic [BPW-1:0]           bank_we,
  output logic [IDX_W+OFF_W-1:0]   bank_waddr,
  output logic [WORD_W-1:0]        fill_word,
  output logic                     fill_sel,
  output logic                     cpu_stall,
  output logic [TAG_W+IDX_W+BEAT_W-1:0] mem_addr,
  output logic                     mem_rd
);
  ifc_state_e        state_q;
  logic [IDX_W-1:0]  sweep_q;
  logic [BEAT_W-1:0] beat_q;
  logic [TAG_W-1:0]  miss_tag_q;
  logic [IDX_W-1:0]  miss_idx_q;
  logic [OFF_W-1:0]  miss_off_q;
  logic [WORD_W-1:0] fill_q, fill_next;
  logic              stall_q, sel_q, rd_q;

  logic              accept, last_beat;
  logic [OFF_W-1:0]  beat_word;
  logic [PART_W-1:0] beat_part;

  assign accept    = (state_q == ST_FILL) && !mem_stall;
  assign last_beat = (beat_q == BEAT_W'(BEATS - 1));
  assign beat_word = beat_q[BEAT_W-1:PART_W];
  assign beat_part = beat_q[PART_W-1:0];

  // requested word assembled from the beats as they arrive
  always_comb begin
    fill_next = fill_q;
    if (accept && (beat_word == miss_off_q))
      fill_next[int'(beat_part)*MEM_W +: MEM_W] = mem_data;
  end

  always_comb begin
    bank_we = '0;
    if (accept) bank_we[beat_part] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_SWEEP;
      sweep_q    <= '0;
      beat_q     <= '0;
      miss_tag_q <= '0;
      miss_idx_q <= '0;
      miss_off_q <= '0;
      fill_q     <= '0;
      stall_q    <= 1'b1;
      sel_q      <= 1'b0;
      rd_q       <= 1'b0;
    end else begin
      case (state_q)
        ST_SWEEP: begin
          sweep_q <= sweep_q + 1'b1;
          if (sweep_q == IDX_W'(SETS - 1)) state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          sel_q <= 1'b0;
          if (look_hit) begin
            stall_q <= 1'b0;
          end else begin
            stall_q    <= 1'b1;
            state_q    <= ST_FILL;
            rd_q       <= 1'b1;
            beat_q     <= '0;
            miss_tag_q <= req_tag;
            miss_idx_q <= req_idx;
            miss_off_q <= req_off;
            fill_q     <= '0;
          end
        end
        ST_FILL: begin
          if (!mem_stall) begin
            fill_q <= fill_next;
            beat_q <= beat_q + 1'b1;
            if (last_beat) begin
              state_q <= ST_LOOKUP;
              rd_q    <= 1'b0;
              stall_q <= 1'b0;
              sel_q   <= 1'b1;
            end
          end
        end
        default: state_q <= ST_SWEEP;
      endcase
    end
  end

  assign clr_en     = (state_q == ST_SWEEP);
  assign clr_idx    = sweep_q;
  assign set_en     = accept && last_beat;
  assign set_idx    = miss_idx_q;
  assign set_tag    = miss_tag_q;
  assign bank_waddr = {miss_idx_q, beat_word};
  assign fill_word  = fill_q;
  assign fill_sel   = sel_q;
  assign cpu_stall  = stall_q;
  assign mem_rd     = rd_q;
  assign mem_addr   = {miss_tag_q, miss_idx_q, beat_q};
endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache #(
  parameter int ADDR_W     = 12,
  parameter int WORD_W     = 32,
  parameter int MEM_W      = 16,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    cpu_addr,
  output logic [WORD_W-1:0]    cpu_instr,
  output logic                 cpu_stall,
  output logic [ADDR_W-$clog2(LINE_WORDS)+$clog2(LINE_WORDS*WORD_W/MEM_W)-1:0] mem_addr,
  output logic                 mem_rd,
  input  logic [MEM_W-1:0]     mem_data,
  input  logic                 mem_stall
);
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int BPW    = WORD_W / MEM_W;
  localparam int PART_W = $clog2(BPW);
  localparam int BEATS  = LINE_WORDS * BPW;
  localparam int BEAT_W = $clog2(BEATS);
  localparam int DEPTH  = SETS * LINE_WORDS;
  localparam int RAM_AW = IDX_W + OFF_W;
  localparam int MADDR_W = TAG_W + IDX_W + BEAT_W;

  logic [OFF_W-1:0]  req_off;
  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic              look_hit;
  logic              clr_en, set_en, fill_sel;
  logic [IDX_W-1:0]  clr_idx, set_idx;
  logic [TAG_W-1:0]  set_tag;
  logic [BPW-1:0]    bank_we;
  logic [RAM_AW-1:0] bank_waddr;
  logic [WORD_W-1:0] fill_word, bank_word;
  logic [MEM_W-1:0]  bank_rd [BPW];

  assign req_off = cpu_addr[OFF_W-1:0];
  assign req_idx = cpu_addr[OFF_W +: IDX_W];
  assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];

  ifc_ctrl #(
    .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W),
    .PART_W(PART_W), .BPW(BPW), .BEAT_W(BEAT_W), .BEATS(BEATS),
    .MEM_W(MEM_W), .WORD_W(WORD_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_tag(req_tag), .req_idx(req_idx), .req_off(req_off),
    .look_hit(look_hit), .mem_data(mem_data), .mem_stall(mem_stall),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .set_en(set_en), .set_idx(set_idx), .set_tag(set_tag),
    .bank_we(bank_we), .bank_waddr(bank_waddr),
    .fill_word(fill_word), .fill_sel(fill_sel),
    .cpu_stall(cpu_stall), .mem_addr(mem_addr), .mem_rd(mem_rd)
  );

  ifc_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .set_en(set_en), .set_idx(set_idx), .set_tag(set_tag),
    .look_idx(req_idx), .look_tag(req_tag), .look_hit(look_hit)
  );

  // one RAM bank per memory-bus slice of a word
  for (genvar p = 0; p < BPW; p++) begin : g_bank
    ifc_data_bank #(.DEPTH(DEPTH), .AW(RAM_AW), .W(MEM_W)) u_bank (
      .clk(clk),
      .we(bank_we[p]),
      .waddr(bank_waddr),
      .wdata(mem_data),
      .raddr({req_idx, req_off}),
      .rdata(bank_rd[p])
    );
  end

  always_comb begin
    for (int p = 0; p < BPW; p++) bank_word[p*MEM_W +: MEM_W] = bank_rd[p];
  end

  assign cpu_instr = fill_sel ? fill_word : bank_word;
endmodule

// File: rtl/ifetch_cache_chk.sv
module ifetch_cache_chk #(
  parameter int MADDR_W = 13,
  parameter int BEAT_W  = 3,
  parameter int SETS    = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               cpu_stall,
  input logic               mem_rd,
  input logic               mem_stall,
  input logic [MADDR_W-1:0] mem_addr
);
  int unsigned since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= 0;
    else if (since_rst < SETS) since_rst <= since_rst + 1;
  end

  AST_SWEEP_HOLDS_CPU: assert property (@(posedge clk) disable iff (rst)
    (since_rst < SETS) |-> (cpu_stall && !mem_rd)); // R2

  AST_READ_ONLY_WHEN_STALLED: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> cpu_stall); // R3

  AST_FILL_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd) |-> (mem_addr[BEAT_W-1:0] == '0)); // R4

  AST_BEAT_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_stall && (mem_addr[BEAT_W-1:0] != '1))
      |=> (mem_rd && (mem_addr == $past(mem_addr) + 1'b1))); // R4

  AST_STALL_HOLDS_BEAT: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && mem_stall) |=> (mem_rd && $stable(mem_addr))); // R5

  AST_LAST_BEAT_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_stall && (mem_addr[BEAT_W-1:0] == '1))
      |=> (!mem_rd && !cpu_stall)); // R7
endmodule

bind ifetch_cache ifetch_cache_chk #(
  .MADDR_W(MADDR_W), .BEAT_W(BEAT_W), .SETS(SETS)
) u_chk (
  .clk(clk), .rst(rst), .cpu_stall(cpu_stall), .mem_rd(mem_rd),
  .mem_stall(mem_stall), .mem_addr(mem_addr)
);

// File: tb/ifetch_cache_bench.sv
`timescale 1ns/1ps
module ifetch_cache_bench;
  localparam int ADDR_W = 12, WORD_W = 32, MEM_W = 16, LINE_WORDS = 4, SETS = 8;
  localparam int OFF_W = 2, IDX_W = 3, BPW = 2, BEATS = 8, MADDR_W = 13;

  logic clk = 1'b0, rst = 1'b1;
  logic [ADDR_W-1:0]  cpu_addr = '0;
  logic [WORD_W-1:0]  cpu_instr;
  logic               cpu_stall, mem_rd;
  logic [MADDR_W-1:0] mem_addr;
  logic [MEM_W-1:0]   mem_data;
  logic               mem_stall = 1'b0;

  int checks = 0, errors = 0;
  int stall_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  logic       toggle = 1'b0;
  logic       sh_valid [SETS];
  logic [ADDR_W-OFF_W-IDX_W-1:0] sh_tag [SETS];

  always #2 clk = ~clk;

  ifetch_cache u_ifetch_cache (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_instr(cpu_instr),
    .cpu_stall(cpu_stall), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_data(mem_data), .mem_stall(mem_stall)
  );

  function automatic logic [MEM_W-1:0] mval(int a);
    return MEM_W'(a * 40503 + 7919) ^ MEM_W'(a >> 2);
  endfunction

  function automatic logic [WORD_W-1:0] exp_word(int w);
    return {mval(w * BPW + 1), mval(w * BPW)};
  endfunction

  assign mem_data = mval(int'(mem_addr));

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic pick_stall();
    logic s;
    case (stall_mode)
      1: begin toggle = ~toggle; s = toggle; end
      2: begin lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]}; s = lfsr[0]; end
      default: s = 1'b0;
    endcase
    return s;
  endfunction

  // called at a negedge; returns at a negedge with the answer on the ports
  task automatic fetch(input int a, input string lbl);
    int idx = (a >> OFF_W) % SETS;
    int tg  = a >> (OFF_W + IDX_W);
    int line = a >> OFF_W;
    logic exp_hit = sh_valid[idx] && (int'(sh_tag[idx]) == tg);
    int edges = 0, held = 0, beats = 0, exp_lat;
    cpu_addr = ADDR_W'(a);
    while (1) begin
      mem_stall = pick_stall();
      if (mem_rd) begin
        if (mem_stall) held++;
        else begin
          chk(int'(mem_addr) == line * BEATS + beats, "R4", mem_addr, line * BEATS + beats);
          beats++;
        end
      end
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (!cpu_stall || edges > 200) break;
    end
    mem_stall = 1'b0;
    exp_lat = exp_hit ? 1 : 1 + BEATS + held;
    chk(edges == exp_lat, exp_hit ? "R3" : (held > 0 ? "R5" : "R7"), edges, exp_lat);
    chk(beats == (exp_hit ? 0 : BEATS), exp_hit ? "R3" : "R4", beats, exp_hit ? 0 : BEATS);
    chk(cpu_instr == exp_word(a), lbl != "" ? lbl : (exp_hit ? "R3" : "R6"),
        cpu_instr, exp_word(a));
    chk(!mem_rd, "R7", mem_rd, 0);
    sh_valid[idx] = 1'b1;
    sh_tag[idx]   = (ADDR_W-OFF_W-IDX_W)'(tg);
  endtask

  task automatic do_reset(input int a);
    rst = 1'b1;
    mem_stall = 1'b0;
    cpu_addr = ADDR_W'(a);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < SETS; s++) sh_valid[s] = 1'b0;
    chk(cpu_stall && !mem_rd, "R2", {cpu_stall, mem_rd}, 2'b10);
    for (int k = 1; k <= SETS; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(cpu_stall && !mem_rd, "R2", {cpu_stall, mem_rd}, 2'b10);
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset(0);
    // sequential sweep over twice the cache: first word of a line misses
    for (int a = 0; a < 64; a++) fetch(a, "");
    // upper half resident now; re-fetch must hit
    for (int a = 32; a < 64; a++) fetch(a, "R8");
    // lower half evicted by same-index lines with another tag
    for (int a = 0; a < 32; a++) fetch(a, "R8");
    // field split: only the top tag bit differs -> miss, offset change -> hit
    fetch(12'h807, "R1");
    fetch(12'h005, "R1");
    fetch(12'h806, "R1");
    fetch(12'h804, "R1");
    // requested word in the last beats, alternating memory stall
    stall_mode = 1;
    for (int k = 0; k < 16; k++) fetch(k * 37 * LINE_WORDS + 3, "R6");
    for (int k = 0; k < 16; k++) fetch(k * 37 * LINE_WORDS + 1, "R8");
    // pseudo-random stall with conflict thrash on one set
    stall_mode = 2;
    for (int k = 0; k < 24; k++) fetch(((k * 5) % 8) * 32 * LINE_WORDS / 4 + 2 + (k % 2) * 12'h400, "");
    for (int a = 256; a < 384; a++) fetch(a, "");
    // a reset drops every line
    stall_mode = 0;
    fetch(12'h17C, "R8");
    do_reset(12'h17C);
    fetch(12'h17C, "R2");
    fetch(12'h17D, "R3");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule